// File: doc/BRIEF.md
# External Asynchronous Memory Port with Bank Decode

This block connects several internal requesters to one external asynchronous memory bus. The requesters are an instruction fetch unit, two data buses and an I/O engine. Each requester presents an address, a direction and write data. The port grants one requester at a time by fixed priority. It then drives a registered 24-bit word address, a 32-bit write data bus with its own output enable, read and write strobes, and one of four bank select lines. The bank is decoded from the two address bits just below the most significant bit.

Each bank has a 3-bit wait count and an acknowledge-enable bit. An access keeps its strobe for one cycle plus the wait count. When the bank's acknowledge-enable bit is set, the access also stays open until the external acknowledge input is seen high. An instruction fetch is always a read of two consecutive external words, and the port packs the two words into one 48-bit instruction word. Each completed access is reported by a one-cycle response that carries the requester number and the returned data.

Top module: `ext_mem_port`

## Requirements
- R1: While a read or write strobe is high, exactly one bank select is high, and its index equals address bits [22:21]. Address bit 23 has no effect on the select. While no strobe is high, all selects are low.
- R2: When the acknowledge-enable bit of the addressed bank is clear, each external word access holds its strobe for exactly 1 + W cycles, where W is that bank's 3-bit wait field (cfg_wait bits [3b+2:3b] for bank b).
- R3: When the acknowledge-enable bit of the addressed bank is set (cfg_ack_en bit b), a word access ends only on a clock edge where ext_ack is high and at least 1 + W strobe cycles have passed.
- R4: Requester priority is fixed, with a lower index winning: 0 is instruction fetch, then 1 and 2 are the data buses, then 3 is I/O.
- R5: A grant is a one-cycle pulse on req_gnt, and at most one bit is set. A grant is issued only when the port is idle, so a started access finishes before the next requester is granted. The grant pulse coincides with the first strobe cycle.
- R6: An instruction fetch reads address A and then address A+1, with no idle cycle between the two reads. Its response data is {word(A+1)[15:0], word(A)[31:0]}.
- R7: The write flag of requester 0 is ignored. An instruction fetch never produces a write strobe.
- R8: A data read responds with rsp_data = {16'h0, word(A)}. A write responds with zero data. rsp_id is the index of the requester that was served, and rsp_valid pulses for one cycle in the first cycle after the strobe drops.
- R9: ext_wdata and ext_data_oe are driven only during write strobes. The write data and address equal those of the request. The read and write strobes are never high together.
- R10: After reset, all strobes, bank selects, the output enable, the grants and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Request pending, one bit per requester |
| req_addr | input | 96 | Word addresses, 24 bits per requester, requester i in bits [24i+23:24i] |
| req_we | input | 4 | Write flag per requester (ignored for requester 0) |
| req_wdata | input | 128 | Write data, 32 bits per requester |
| req_gnt | output | 4 | One-cycle grant pulse |
| rsp_valid | output | 1 | Access complete |
| rsp_id | output | 2 | Index of the requester served |
| rsp_data | output | 48 | Read data or packed instruction |
| cfg_wait | input | 12 | Wait count, 3 bits per bank |
| cfg_ack_en | input | 4 | Acknowledge-enable bit per bank |
| ext_addr | output | 24 | External word address |
| ext_bank_sel | output | 4 | One-hot bank select |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_wdata | output | 32 | External write data |
| ext_data_oe | output | 1 | Write data output enable |
| ext_rdata | input | 32 | External read data |
| ext_ack | input | 1 | External acknowledge |

## Verification
The bench builds the port with its default parameters: four requesters, four banks, 3-bit wait fields, a 24-bit address and a 32-bit data bus. With these values the largest wait count of seven is reachable. An acknowledge arriving both before and after the wait count expires can be tested. An instruction fetch at 0x1FFFFF crosses from bank 0 into bank 1 between its two reads, and a set bit 23 shows that the bank field is decoded below it. Four simultaneous requests expose the full priority order.

// File: rtl/ext_port_pkg.sv
package ext_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } seq_state_e;

  localparam int unsigned IFETCH_IDX = 0;
endpackage

// File: rtl/ext_port_arb.sv
module ext_port_arb #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  // lowest index wins: scan downward so the last hit is the smallest index
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ext_port_bank_dec.sv
module ext_port_bank_dec #(
  parameter int NUM_BANKS = 4,
  parameter int WS_W      = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [BANK_W-1:0]         bank,
  input  logic [NUM_BANKS*WS_W-1:0] cfg_wait,
  input  logic [NUM_BANKS-1:0]      cfg_ack_en,
  output logic [NUM_BANKS-1:0]      sel,
  output logic [WS_W-1:0]           wait_cnt,
  output logic                      ack_en
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign sel[b] = (bank == BANK_W'(b));
  end

  assign wait_cnt = cfg_wait[bank*WS_W +: WS_W];
  assign ack_en   = cfg_ack_en[bank];
endmodule

// File: rtl/ext_port_seq.sv
module ext_port_seq
  import ext_port_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int WS_W      = 3,
  parameter int IDX_W     = 2,
  localparam int INSTR_W  = DATA_W + DATA_W / 2,
  localparam int HI_W     = INSTR_W - DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [IDX_W-1:0]     start_id,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic                 start_we,
  input  logic [DATA_W-1:0]    start_wdata,
  input  logic [NUM_BANKS-1:0] start_sel,
  input  logic [WS_W-1:0]      start_wait,
  input  logic                 start_ack_en,
  input  logic [NUM_BANKS-1:0] nxt_sel,
  input  logic [WS_W-1:0]      nxt_wait,
  input  logic                 nxt_ack_en,
  input  logic [ADDR_W-1:0]    nxt_addr,
  input  logic [DATA_W-1:0]    ext_rdata,
  input  logic                 ext_ack,
  output logic                 busy,
  output logic [ADDR_W-1:0]    ext_addr,
  output logic [NUM_BANKS-1:0] ext_bank_sel,
  output logic                 ext_rd,
  output logic                 ext_wr,
  output logic [DATA_W-1:0]    ext_wdata,
  output logic                 ext_data_oe,
  output logic                 rsp_valid,
  output logic [IDX_W-1:0]     rsp_id,
  output logic [INSTR_W-1:0]   rsp_data
);
  seq_state_e          state;
  logic [WS_W-1:0]     cnt_q;
  logic                ack_en_q;
  logic [IDX_W-1:0]    id_q;
  logic                is_if_q;
  logic [DATA_W-1:0]   lo_q;
  logic                word_done;
  logic                start_if;

  assign busy      = (state != ST_IDLE);
  assign start_if  = (start_id == IDX_W'(IFETCH_IDX));
  assign word_done = busy && (cnt_q == '0) && (!ack_en_q || ext_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt_q        <= '0;
      ack_en_q     <= 1'b0;
      id_q         <= '0;
      is_if_q      <= 1'b0;
      lo_q         <= '0;
      ext_addr     <= '0;
      ext_bank_sel <= '0;
      ext_rd       <= 1'b0;
      ext_wr       <= 1'b0;
      ext_wdata    <= '0;
      ext_data_oe  <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_id       <= '0;
      rsp_data     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state        <= ST_LO;
            ext_addr     <= start_addr;
            ext_bank_sel <= start_sel;
            cnt_q        <= start_wait;
            ack_en_q     <= start_ack_en;
            id_q         <= start_id;
            is_if_q      <= start_if;
            ext_rd       <= start_if || !start_we;
            ext_wr       <= !start_if && start_we;
            ext_data_oe  <= !start_if && start_we;
            ext_wdata    <= start_wdata;
          end
        end
        ST_LO, ST_HI: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (word_done) begin
            if (state == ST_LO && is_if_q) begin
              // first half of a packed fetch: move straight to the next word
              state        <= ST_HI;
              lo_q         <= ext_rdata;
              ext_addr     <= nxt_addr;
              ext_bank_sel <= nxt_sel;
              cnt_q        <= nxt_wait;
              ack_en_q     <= nxt_ack_en;
            end else begin
              state        <= ST_IDLE;
              ext_rd       <= 1'b0;
              ext_wr       <= 1'b0;
              ext_data_oe  <= 1'b0;
              ext_bank_sel <= '0;
              rsp_valid    <= 1'b1;
              rsp_id       <= id_q;
              if (state == ST_HI)
                rsp_data <= {ext_rdata[HI_W-1:0], lo_q};
              else if (ext_wr)
                rsp_data <= '0;
              else
                rsp_data <= {{HI_W{1'b0}}, ext_rdata};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_mem_port.sv
module ext_mem_port #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int NUM_REQ   = 4,
  parameter int NUM_BANKS = 4,
  parameter int WS_W      = 3,
  localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int INSTR_W  = DATA_W + DATA_W / 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_REQ-1:0]          req_valid,
  input  logic [NUM_REQ*ADDR_W-1:0]   req_addr,
  input  logic [NUM_REQ-1:0]          req_we,
  input  logic [NUM_REQ*DATA_W-1:0]   req_wdata,
  output logic [NUM_REQ-1:0]          req_gnt,
  output logic                        rsp_valid,
  output logic [IDX_W-1:0]            rsp_id,
  output logic [INSTR_W-1:0]          rsp_data,
  input  logic [NUM_BANKS*WS_W-1:0]   cfg_wait,
  input  logic [NUM_BANKS-1:0]        cfg_ack_en,
  output logic [ADDR_W-1:0]           ext_addr,
  output logic [NUM_BANKS-1:0]        ext_bank_sel,
  output logic                        ext_rd,
  output logic                        ext_wr,
  output logic [DATA_W-1:0]           ext_wdata,
  output logic                        ext_data_oe,
  input  logic [DATA_W-1:0]           ext_rdata,
  input  logic                        ext_ack
);
  localparam int BANK_LSB = ADDR_W - 1 - BANK_W;

  logic [ADDR_W-1:0] req_addr_a  [NUM_REQ];
  logic [DATA_W-1:0] req_wdata_a [NUM_REQ];

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_unpack
    assign req_addr_a[i]  = req_addr[i*ADDR_W +: ADDR_W];
    assign req_wdata_a[i] = req_wdata[i*DATA_W +: DATA_W];
  end

  logic             any_req;
  logic [IDX_W-1:0] win;
  logic             busy;
  logic             start;

  ext_port_arb #(.NUM_REQ(NUM_REQ)) u_arb (
    .req (req_valid),
    .any (any_req),
    .idx (win)
  );

  assign start = any_req && !busy;

  logic [ADDR_W-1:0]    win_addr;
  logic [NUM_BANKS-1:0] st_sel;
  logic [WS_W-1:0]      st_wait;
  logic                 st_ack_en;
  assign win_addr = req_addr_a[win];

  ext_port_bank_dec #(.NUM_BANKS(NUM_BANKS), .WS_W(WS_W)) u_dec_start (
    .bank       (win_addr[BANK_LSB +: BANK_W]),
    .cfg_wait   (cfg_wait),
    .cfg_ack_en (cfg_ack_en),
    .sel        (st_sel),
    .wait_cnt   (st_wait),
    .ack_en     (st_ack_en)
  );

  logic [ADDR_W-1:0]    nxt_addr;
  logic [NUM_BANKS-1:0] nx_sel;
  logic [WS_W-1:0]      nx_wait;
  logic                 nx_ack_en;
  assign nxt_addr = ext_addr + ADDR_W'(1);

  ext_port_bank_dec #(.NUM_BANKS(NUM_BANKS), .WS_W(WS_W)) u_dec_next (
    .bank       (nxt_addr[BANK_LSB +: BANK_W]),
    .cfg_wait   (cfg_wait),
    .cfg_ack_en (cfg_ack_en),
    .sel        (nx_sel),
    .wait_cnt   (nx_wait),
    .ack_en     (nx_ack_en)
  );

  always_ff @(posedge clk) begin
    if (rst) req_gnt <= '0;
    else     req_gnt <= start ? (NUM_REQ'(1) << win) : '0;
  end

  ext_port_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .WS_W      (WS_W),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_id     (win),
    .start_addr   (win_addr),
    .start_we     (req_we[win]),
    .start_wdata  (req_wdata_a[win]),
    .start_sel    (st_sel),
    .start_wait   (st_wait),
    .start_ack_en (st_ack_en),
    .nxt_sel      (nx_sel),
    .nxt_wait     (nx_wait),
    .nxt_ack_en   (nx_ack_en),
    .nxt_addr     (nxt_addr),
    .ext_rdata    (ext_rdata),
    .ext_ack      (ext_ack),
    .busy         (busy),
    .ext_addr     (ext_addr),
    .ext_bank_sel (ext_bank_sel),
    .ext_rd       (ext_rd),
    .ext_wr       (ext_wr),
    .ext_wdata    (ext_wdata),
    .ext_data_oe  (ext_data_oe),
    .rsp_valid    (rsp_valid),
    .rsp_id       (rsp_id),
    .rsp_data     (rsp_data)
  );
endmodule

// File: rtl/ext_mem_port_chk.sv
module ext_mem_port_chk #(
  parameter int ADDR_W    = 24,
  parameter int NUM_REQ   = 4,
  parameter int NUM_BANKS = 4,
  localparam int IDX_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_REQ-1:0]   req_gnt,
  input logic                 rsp_valid,
  input logic [IDX_W-1:0]     rsp_id,
  input logic [NUM_BANKS-1:0] cfg_ack_en,
  input logic [ADDR_W-1:0]    ext_addr,
  input logic [NUM_BANKS-1:0] ext_bank_sel,
  input logic                 ext_rd,
  input logic                 ext_wr,
  input logic                 ext_data_oe,
  input logic                 ext_ack
);
  logic                 strobe;
  logic [BANK_W-1:0]    bank_d;
  logic [NUM_BANKS-1:0] ack_en_d;
  logic                 ack_d;

  assign strobe = ext_rd || ext_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_d   <= '0;
      ack_en_d <= '0;
      ack_d    <= 1'b0;
    end else begin
      bank_d   <= ext_addr[ADDR_W-1-BANK_W +: BANK_W];
      ack_en_d <= cfg_ack_en;
      ack_d    <= ext_ack;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $onehot(ext_bank_sel)); // R1
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> (ext_bank_sel == '0)); // R1
  AST_ACK_SEEN: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && ack_en_d[bank_d]) |-> ack_d); // R3
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_gnt)); // R5
  AST_GNT_START: assert property (@(posedge clk) disable iff (rst)
    (|req_gnt) |-> (strobe && !$past(strobe))); // R5
  AST_RSP_END: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!strobe && $past(strobe))); // R8
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (ext_rd && $past(ext_rd) && ext_addr != $past(ext_addr))
      |-> ext_addr == $past(ext_addr) + ADDR_W'(1)); // R6
  AST_FETCH_RD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_id == '0) |-> !$past(ext_wr)); // R7
  AST_OE_WR: assert property (@(posedge clk) disable iff (rst)
    ext_data_oe |-> ext_wr); // R9
  AST_WR_OE: assert property (@(posedge clk) disable iff (rst)
    ext_wr |-> ext_data_oe); // R9
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd && ext_wr)); // R9
endmodule

bind ext_mem_port ext_mem_port_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_REQ   (NUM_REQ),
  .NUM_BANKS (NUM_BANKS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_gnt      (req_gnt),
  .rsp_valid    (rsp_valid),
  .rsp_id       (rsp_id),
  .cfg_ack_en   (cfg_ack_en),
  .ext_addr     (ext_addr),
  .ext_bank_sel (ext_bank_sel),
  .ext_rd       (ext_rd),
  .ext_wr       (ext_wr),
  .ext_data_oe  (ext_data_oe),
  .ext_ack      (ext_ack)
);

// File: tb/tb_ext_mem_port.sv
module tb_ext_mem_port;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int NR = 4;
  localparam int NB = 4;
  localparam int WS = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NR-1:0] req_valid = '0;
  logic [NR*AW-1:0] req_addr = '0;
  logic [NR-1:0] req_we = '0;
  logic [NR*DW-1:0] req_wdata = '0;
  logic [NR-1:0] req_gnt;
  logic          rsp_valid;
  logic [1:0]    rsp_id;
  logic [47:0]   rsp_data;
  logic [NB*WS-1:0] cfg_wait = '0;
  logic [NB-1:0] cfg_ack_en = '0;
  logic [AW-1:0] ext_addr;
  logic [NB-1:0] ext_bank_sel;
  logic          ext_rd, ext_wr, ext_data_oe;
  logic [DW-1:0] ext_wdata;
  logic [DW-1:0] ext_rdata;
  logic          ext_ack = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {~a[7:0], a};
  endfunction

  assign ext_rdata = mem_word(ext_addr);

  ext_mem_port dut (.*);

  int checks = 0;
  int errors = 0;
  int ack_dly = 0;

  // bus monitor, sampled away from the active edge
  int k = 0, strobe_cnt = 0, sel_err = 0, oe_err = 0, rsp_cnt = 0, nrd = 0;
  logic prev_strobe = 1'b0;
  logic [23:0] prev_addr = '0;
  logic [23:0] rd_addr [4];
  logic wr_seen = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;

  always @(negedge clk) begin
    if (ext_rd || ext_wr) begin
      if (!prev_strobe || ext_addr != prev_addr) begin
        k = 0;
        if (ext_rd && nrd < 4) begin rd_addr[nrd] = ext_addr; nrd++; end
      end else k++;
      strobe_cnt++;
      if (ext_bank_sel != (NB'(1) << ext_addr[22:21])) sel_err++;
      if (ext_rd && ext_data_oe) oe_err++;
      if (ext_wr) begin
        wr_seen = 1'b1; wr_addr = ext_addr; wr_data = ext_wdata;
        if (!ext_data_oe) oe_err++;
      end
    end else begin
      if (ext_bank_sel != '0) sel_err++;
      if (ext_data_oe) oe_err++;
    end
    if (rsp_valid) rsp_cnt++;
    ext_ack = (ext_rd || ext_wr) && (k >= ack_dly);
    prev_strobe = ext_rd || ext_wr;
    prev_addr = ext_addr;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int word_len(input logic [23:0] a);
    int w = int'(cfg_wait[a[22:21]*WS +: WS]);
    int d = cfg_ack_en[a[22:21]] ? ack_dly : 0;
    return 1 + ((w > d) ? w : d);
  endfunction

  task automatic run_txn(input int id, input logic [23:0] a, input logic we, input logic [31:0] wd);
    bit is_if = (id == 0);
    bit eff_we = we && !is_if;
    logic [47:0] exp_d;
    int exp_len, se0, oe0, g;
    exp_len = word_len(a) + (is_if ? word_len(a + 24'd1) : 0);
    if (is_if) exp_d = {mem_word(a + 24'd1)[15:0], mem_word(a)};
    else if (eff_we) exp_d = '0;
    else exp_d = {16'h0, mem_word(a)};
    @(negedge clk);
    req_valid[id] = 1'b1;
    req_addr[id*AW +: AW] = a;
    req_we[id] = we;
    req_wdata[id*DW +: DW] = wd;
    strobe_cnt = 0; nrd = 0; wr_seen = 1'b0;
    se0 = sel_err; oe0 = oe_err;
    g = 0;
    do begin @(negedge clk); g++; end while (!req_gnt[id] && g < 300);
    chk(req_gnt == (NR'(1) << id), "R5 grant", 64'(req_gnt), 64'(NR'(1) << id));
    req_valid[id] = 1'b0;
    g = 0;
    while (!rsp_valid && g < 300) begin @(negedge clk); g++; end
    chk(rsp_valid, "R8 response", 64'(rsp_valid), 64'd1);
    chk(rsp_id == 2'(id), "R8 rsp_id", 64'(rsp_id), 64'(id));
    chk(rsp_data == exp_d, is_if ? "R6 packed data" : "R8 data", 64'(rsp_data), 64'(exp_d));
    chk(strobe_cnt == exp_len, (cfg_ack_en != 0) ? "R3 strobe length" : "R2 strobe length",
        64'(strobe_cnt), 64'(exp_len));
    if (is_if) begin
      chk(nrd == 2 && rd_addr[0] == a && rd_addr[1] == a + 24'd1, "R6 fetch addresses",
          64'({rd_addr[0], rd_addr[1]}), 64'({a, a + 24'd1}));
      chk(!wr_seen, "R7 no write on fetch", 64'(wr_seen), 64'd0);
    end else if (eff_we) begin
      chk(wr_seen && wr_addr == a && wr_data == wd, "R9 write bus",
          64'({wr_addr, wr_data}), 64'({a, wd}));
    end else begin
      chk(!wr_seen, "R9 no write on read", 64'(wr_seen), 64'd0);
    end
    chk(sel_err == se0, "R1 bank select", 64'(sel_err - se0), 64'd0);
    chk(oe_err == oe0, "R9 output enable", 64'(oe_err - oe0), 64'd0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!ext_rd && !ext_wr && !ext_data_oe && ext_bank_sel == 0 && req_gnt == 0 && !rsp_valid,
        "R10 reset state", 64'({ext_rd, ext_wr, ext_data_oe, ext_bank_sel, req_gnt, rsp_valid}), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2: zero wait and maximum wait without acknowledge
    cfg_wait = {3'd7, 3'd2, 3'd5, 3'd0}; cfg_ack_en = '0; ack_dly = 0;
    run_txn(1, 24'h000010, 1'b0, '0);
    run_txn(2, 24'h600020, 1'b0, '0);
    run_txn(3, 24'h200040, 1'b1, 32'hDEADBEEF);
    // R1: bit 23 set, bank still from bits 22:21
    run_txn(1, 24'hC00033, 1'b0, '0);
    // R3: acknowledge late and early
    cfg_ack_en = 4'b0011; ack_dly = 6;
    run_txn(2, 24'h000100, 1'b0, '0);
    ack_dly = 2;
    run_txn(3, 24'h200101, 1'b1, 32'h12345678);
    // R6: fetch crossing from bank 0 into bank 1
    cfg_ack_en = 4'b0010; ack_dly = 3;
    run_txn(0, 24'h1FFFFF, 1'b0, '0);
    // R7: fetch with write flag set
    cfg_ack_en = '0;
    run_txn(0, 24'h400200, 1'b1, 32'hCAFEF00D);

    // R4: all four requesters at once
    begin
      int order [4];
      int g, r0;
      @(negedge clk);
      for (int i = 0; i < NR; i++) begin
        req_valid[i] = 1'b1;
        req_addr[i*AW +: AW] = 24'(24'h000300 + i);
        req_we[i] = 1'b0;
      end
      r0 = rsp_cnt;
      for (int n = 0; n < NR; n++) begin
        g = 0;
        do begin @(negedge clk); g++; end while (req_gnt == 0 && g < 300);
        order[n] = 0;
        for (int i = 0; i < NR; i++) if (req_gnt[i]) order[n] = i;
        chk(order[n] == n, "R4 priority order", 64'(order[n]), 64'(n));
        chk(rsp_cnt - r0 == n, "R5 grant after completion", 64'(rsp_cnt - r0), 64'(n));
        req_valid[order[n]] = 1'b0;
      end
      g = 0;
      do begin @(negedge clk); g++; end while (!rsp_valid && g < 300);
      chk(rsp_id == 2'd3, "R4 last served", 64'(rsp_id), 64'd3);
    end

    // random traffic
    for (int t = 0; t < 60; t++) begin
      cfg_wait = NB*WS'($urandom);
      cfg_ack_en = NB'($urandom);
      ack_dly = int'($urandom % 6);
      run_txn(int'($urandom % NR), 24'($urandom), 1'($urandom), $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule